// File: doc/BRIEF.md
# Compressed Background Frame Differencer

This stage flags moving pixels in a raster stream of 8-bit grayscale frames. Each pixel that arrives over a valid/ready handshake is compared against a background taken from the previous frame. The pixel leaves unchanged on the output handshake, together with a one-bit motion flag. The flag is set when the absolute difference between the pixel and the background is larger than a per-pixel threshold input.

The background is not kept at full resolution. While a frame streams in, every 2x2 window is summed into one 10-bit value, so storage is a quarter of the pixel count. A line buffer of 9-bit horizontal pair sums carries the top row of each window until the bottom row arrives. Two background banks swap roles at each frame boundary: one bank is filled from the current frame while the other is read. On the read side, the stored sum for window (x>>1, y>>1) is divided by four and serves all four pixels of that window. Frame size is set by parameters: the production configuration is 640x480, and the defaults are kept small.

Top module: `motion_bgdiff`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Every accepted pixel appears on `out_data` with `out_valid` high on the cycle after it is accepted. Pixels leave in order, with none dropped and none duplicated.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. On the next cycle `out_valid`, `out_data` and `out_motion` keep their values.
- R4: Every pixel of the first frame after reset leaves with `out_motion` equal to 0, whatever the threshold.
- R5: The background for a pixel of frame N is the sum of the four pixels of its 2x2 window in frame N-1, shifted right by 2. Each sum is written once, when the pixel at odd x and odd y of the window is accepted.
- R6: `out_motion` is 1 exactly when |pixel − background| is strictly greater than `thresh`. A difference equal to `thresh` gives 0.
- R7: All four pixels (x, y) that share x>>1 and y>>1 use the same stored background value.
- R8: Pixels are taken in raster order, with x advancing first. After the last pixel of a frame, position returns to (0, 0). Frame N is compared only with frame N-1, never with an older frame.
- R9: `thresh` is sampled together with each accepted pixel, so it may change from one pixel to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Stage can take a pixel this cycle |
| in_data | input | PIX_W | Grayscale input pixel |
| thresh | input | PIX_W | Motion threshold for the accepted pixel |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_data | output | PIX_W | Forwarded pixel |
| out_motion | output | 1 | Motion flag for `out_data` |

## Verification
The assertions check the handshake behaviour on every cycle: a stalled output stays frozen and blocks input, an accepted pixel shows up on the next cycle, and no flag is raised during the first frame. They also check the internal events: background writes happen only at odd-odd positions, and position wraps after the frame-end event. The background arithmetic can only be shown by the bench's scenarios. These include the window sums, the divide by four, the sharing of one value across four pixels, the strict threshold comparison at equality, and the use of N-1 rather than an older frame. The bench covers these by sweeping whole frames of a small image against its own window model, with random stalls on both sides.

// File: rtl/motion_bgdiff_pkg.sv
package motion_bgdiff_pkg;
  localparam int PIX_W = 8;
  localparam int PAIR_W = PIX_W + 1;
  localparam int SUM_W = PIX_W + 2;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [PAIR_W-1:0] pair_t;
  typedef logic [SUM_W-1:0]  wsum_t;

  function automatic pair_t pair_add(input pix_t a, input pix_t b);
    return pair_t'(a) + pair_t'(b);
  endfunction

  function automatic wsum_t quad_add(input pair_t top, input pair_t bot);
    return wsum_t'(top) + wsum_t'(bot);
  endfunction

  function automatic pix_t win_avg(input wsum_t s);
    return pix_t'(s >> 2);
  endfunction

  function automatic pix_t abs_diff(input pix_t a, input pix_t b);
    return (a >= b) ? pix_t'(a - b) : pix_t'(b - a);
  endfunction
endpackage

// File: rtl/motion_bgdiff_raster.sv
module motion_bgdiff_raster #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic          frame_end,
  output logic          bank,
  output logic          bg_ok
);
  localparam logic [XW-1:0] XLAST = XW'(IMG_W - 1);
  localparam logic [YW-1:0] YLAST = YW'(IMG_H - 1);

  logic row_end;
  assign row_end   = step && (px_x == XLAST);
  assign frame_end = row_end && (px_y == YLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_x  <= '0;
      px_y  <= '0;
      bank  <= 1'b0;
      bg_ok <= 1'b0;
    end else if (step) begin
      if (row_end) begin
        px_x <= '0;
        px_y <= (px_y == YLAST) ? '0 : px_y + 1'b1;
      end else begin
        px_x <= px_x + 1'b1;
      end
      if (frame_end) begin
        bank  <= ~bank;
        bg_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/motion_bgdiff_accum.sv
module motion_bgdiff_accum
  import motion_bgdiff_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H),
  localparam int BG_W = IMG_W / 2,
  localparam int BG_N = BG_W * (IMG_H / 2),
  localparam int LW = $clog2(BG_W),
  localparam int AW = $clog2(BG_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [XW-1:0] px_x,
  input  logic [YW-1:0] px_y,
  input  pix_t          pix,
  output logic [AW-1:0] win_addr,
  output logic          bg_we,
  output wsum_t         bg_wdata
);
  pix_t  left_q;
  pair_t line_q [BG_W];
  pair_t pair_now;
  logic [LW-1:0] col;

  assign col      = LW'(px_x >> 1);
  assign win_addr = AW'(px_y >> 1) * AW'(BG_W) + AW'(col);
  assign pair_now = pair_add(left_q, pix);
  assign bg_we    = step && px_x[0] && px_y[0];
  assign bg_wdata = quad_add(line_q[col], pair_now);

  always_ff @(posedge clk) begin
    if (!rst_n) left_q <= '0;
    else if (step && !px_x[0]) left_q <= pix;
  end

  always_ff @(posedge clk) begin
    if (step && px_x[0] && !px_y[0]) line_q[col] <= pair_now;
  end
endmodule

// File: rtl/motion_bgdiff_bgstore.sv
module motion_bgdiff_bgstore
  import motion_bgdiff_pkg::*;
#(
  parameter int DEPTH = 768,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] addr,
  input  wsum_t         wdata,
  output wsum_t         rdata
);
  wsum_t rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    wsum_t mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wbank == 1'(b))) mem[addr] <= wdata;
    end
    assign rd[b] = mem[addr];
  end

  assign rdata = rd[~wbank];
endmodule

// File: rtl/motion_bgdiff.sv
module motion_bgdiff
  import motion_bgdiff_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H),
  localparam int BG_N = (IMG_W / 2) * (IMG_H / 2),
  localparam int AW = $clog2(BG_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic [PIX_W-1:0] thresh,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_motion
);
  logic          step;
  logic [XW-1:0] px_x;
  logic [YW-1:0] px_y;
  logic          frame_end, bank, bg_ok, bg_we;
  logic [AW-1:0] win_addr;
  wsum_t         bg_wdata, bg_rdata;
  pix_t          bg_pix, diff;
  logic          motion_c;

  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;

  motion_bgdiff_raster #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_raster (
    .clk(clk), .rst_n(rst_n), .step(step), .px_x(px_x), .px_y(px_y),
    .frame_end(frame_end), .bank(bank), .bg_ok(bg_ok)
  );

  motion_bgdiff_accum #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_accum (
    .clk(clk), .rst_n(rst_n), .step(step), .px_x(px_x), .px_y(px_y),
    .pix(in_data), .win_addr(win_addr), .bg_we(bg_we), .bg_wdata(bg_wdata)
  );

  motion_bgdiff_bgstore #(.DEPTH(BG_N)) u_store (
    .clk(clk), .we(bg_we), .wbank(bank), .addr(win_addr),
    .wdata(bg_wdata), .rdata(bg_rdata)
  );

  assign bg_pix   = win_avg(bg_rdata);
  assign diff     = abs_diff(in_data, bg_pix);
  assign motion_c = bg_ok && (diff > thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_motion <= 1'b0;
    end else if (step) begin
      out_valid  <= 1'b1;
      out_data   <= in_data;
      out_motion <= motion_c;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/motion_bgdiff_chk.sv
module motion_bgdiff_chk #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int PW = 8,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H),
  localparam int FRAME = IMG_W * IMG_H
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [PW-1:0] in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_data,
  input logic          out_motion,
  input logic          step,
  input logic          bg_we,
  input logic          frame_end,
  input logic [XW-1:0] px_x,
  input logic [YW-1:0] px_y
);
  int  seen;
  logic warm;
  assign warm = (seen >= FRAME);

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 0;
    else if (in_valid && in_ready && !warm) seen <= seen + 1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_motion)); // R3
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R3
  AST_PIXEL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R2
  AST_QUIET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !warm |=> !out_motion); // R4
  AST_WRITE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    bg_we |-> step && px_x[0] && px_y[0]); // R5
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> px_x == '0 && px_y == '0); // R8
  AST_X_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    px_x <= XW'(IMG_W - 1)); // R8
endmodule

bind motion_bgdiff motion_bgdiff_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PW(motion_bgdiff_pkg::PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_motion(out_motion),
  .step(step), .bg_we(bg_we), .frame_end(frame_end), .px_x(px_x), .px_y(px_y)
);

// File: tb/motion_bgdiff_bench.sv
module motion_bgdiff_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int H = 4;
  localparam int NFRAMES = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [7:0] thresh = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_motion;

  int errors = 0;
  int checks = 0;
  int prevf [H][W];
  int curf  [H][W];
  logic [7:0] q_data [$];
  logic       q_mot  [$];
  logic       stall_on = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  logic       was_stall = 1'b0;
  logic [7:0] st_data;
  logic       st_mot;

  always #(CLK_PERIOD/2) clk = ~clk;

  motion_bgdiff #(.IMG_W(W), .IMG_H(H)) u_motion_bgdiff (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .thresh(thresh), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_motion(out_motion)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int pattern(int f, int x, int y);
    return (x * 37 + y * 91 + f * 67 + ((x * y * f) % 7) * 19) % 256;
  endfunction

  // downstream ready: pseudo-random stalls, changed just after the edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_on ? (lfsr[2:0] > 3'd2) : 1'b1;
  end

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stall) begin
        check(out_valid && out_data == st_data && out_motion == st_mot,
              "R3 stalled output held", out_data, st_data);
      end
      was_stall = 1'b0;
      if (out_valid && !out_ready) begin
        check(!in_ready, "R3 in_ready low while stalled", in_ready, 0);
        was_stall = 1'b1;
        st_data = out_data;
        st_mot = out_motion;
      end else if (out_valid && out_ready) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R2 unexpected output pixel", out_data, -1);
        end else begin
          logic [7:0] ed;
          logic em;
          ed = q_data.pop_front();
          em = q_mot.pop_front();
          check(out_data == ed, "R2 forwarded pixel", out_data, ed);
          // R4 R5 R6 R7 R8 R9: motion flag against the window model
          check(out_motion == em, "R6 motion flag (R4 R5 R7 R8 R9)", out_motion, em);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "R2 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int idx = 0;
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset outputs", out_valid, 0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", in_ready, 1);
    for (int f = 0; f < NFRAMES; f++) begin
      for (int y = 0; y < H; y++) begin
        for (int x = 0; x < W; x++) begin
          int p, bg, d, t;
          logic m;
          p = pattern(f, x, y);
          bg = (prevf[y & ~1][x & ~1] + prevf[y & ~1][x | 1]
              + prevf[y | 1][x & ~1] + prevf[y | 1][x | 1]) >> 2;
          d = (p > bg) ? p - bg : bg - p;
          case (idx % 4)
            0: t = d;
            1: t = (d > 0) ? d - 1 : 0;
            2: t = (d < 255) ? d + 1 : 255;
            default: t = 40;
          endcase
          if (f == 0) t = 0;
          m = (f > 0) && (d > t);
          curf[y][x] = p;
          if (idx % 5 == 3) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
          end
          @(posedge clk);
          #1;
          in_valid = 1'b1;
          in_data = 8'(p);
          thresh = 8'(t);
          forever begin
            @(negedge clk);
            if (in_ready) break;
          end
          q_data.push_back(8'(p));
          q_mot.push_back(m);
          idx++;
        end
      end
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++) prevf[y][x] = curf[y][x];
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    stall_on = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(q_data.size() == 0, "R2 all pixels delivered", q_data.size(), 0);
    finish_run();
  end
endmodule